// File: doc/BRIEF.md
# Interrupt controller system register front end

This block is the bus-facing register file of a single-core nested vectored interrupt controller. It owns a 4 KB address window and decodes each request by offset and access size. Word accesses to the middle of the window go straight to a separate distributor register port. The block itself answers the rest: the interrupt-line count, the system tick control and reload words, the interrupt state readback, a software trigger, and a small identification table at the top of the window.

The block keeps one pending bit per interrupt line. Peripherals set these bits, the arbiter clears them, and software writes to the trigger register also set them. The pending array leaves the block so that an external arbiter can choose the winning vector. That vector comes back in on `hp_vec` and appears in the state readback. The tick counter is outside this block. It takes its enable bits and reload value from this block and returns a one-cycle pulse when it wraps. The pulse sets a count flag, and reading the control word clears that flag.

Every request gets a response in the following cycle: `bus_ready` is high, and `bus_rdata` and `bus_err` are valid in that same cycle.

Top module: `intc_sysreg_front`

## Requirements
- R1: After reset, `bus_ready`, `bus_err`, `bus_rdata`, `tick_ctrl_o`, `tick_reload_o` and `pend_o` are all zero. The tick control word reads back as zero. `ctl_enable_o` and `cpu_if_enable_o` are both 1.
- R2: A request sampled at a clock edge raises `bus_ready` for the following cycle. `bus_err` and `bus_rdata` are valid in that cycle. When `bus_err` is high, `bus_rdata` is 0.
- R3: A legal word access to an aligned offset from 0x100 to 0xCFF drives `dist_req` high in the same cycle. `dist_addr`, `dist_wr` and `dist_wdata` mirror the bus in that cycle. For a read, the response carries the `dist_rdata` value from that cycle. No other request raises `dist_req`.
- R4: A read at offset 0xFE0 + 4k, for k from 0 to 7, returns entry k of the identification table in bits 7:0. The entries are 0x00, 0xB0, 0x1B, 0x00, 0x0D, 0xE0, 0x05, 0xB1. Identification reads are legal at byte size (`bus_word`=0) as well as word size.
- R5: An identification read at an offset of 0xFE0 or above whose two low bits are not zero returns 0 without error.
- R6: The following requests are illegal: a byte access below 0xFE0, a word access below 0xFE0 with nonzero low address bits, an undecoded offset, any write at or above 0xFE0, and a read of 0xF00. An illegal request sets `bus_err` and changes no state.
- R7: A read at 0x004 returns NUM_IRQ/32 − 1.
- R8: Offset 0x010 is the tick control word. A write loads bits 2:0 into `tick_ctrl_o`. A read returns bits 2:0 and the count flag in bit 16, then clears the flag.
- R9: A `tick_flag_pulse` sets the count flag. If a pulse arrives in the same cycle as a clearing read, the read returns the old flag and the flag is 1 afterwards.
- R10: Offset 0x014 holds a 24-bit reload value. It drives `tick_reload_o` and reads back with bits 31:24 zero.
- R11: A read at 0xD04 returns bit 22 set when any pending bit at index 32 or above is set. Bits 21:12 hold `hp_vec`, unless `hp_vec` is 1023; in that case those bits are 0.
- R12: A word write at 0xF00 takes bits 8:0 of the data as a line number. If that number is below NUM_IRQ, the line's pending bit is set. Otherwise the write has no effect on `pend_o`, and it raises no error.
- R13: A high bit of `pend_set` sets that pending bit and a high bit of `pend_clr` clears it. When both are high for the same line, the set wins.
- R14: Word writes to the read-only offsets 0x004 and 0xD04 are accepted without error and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Illegal access, valid with bus_ready |
| dist_req | output | 1 | Forwarded distributor access |
| dist_wr | output | 1 | Write flag toward the distributor |
| dist_addr | output | 12 | Offset toward the distributor |
| dist_wdata | output | 32 | Write data toward the distributor |
| dist_rdata | input | 32 | Distributor read data, same cycle |
| hp_vec | input | 10 | Highest pending vector, 1023 = none |
| tick_flag_pulse | input | 1 | Tick wrap pulse, sets the count flag |
| tick_ctrl_o | output | 3 | Tick enable and mode bits |
| tick_reload_o | output | 24 | Tick reload value |
| pend_set | input | NUM_IRQ | Per-line pending set |
| pend_clr | input | NUM_IRQ | Per-line pending clear |
| pend_o | output | NUM_IRQ | Pending bits |
| ctl_enable_o | output | 1 | Global controller enable |
| cpu_if_enable_o | output | 1 | CPU interface enable |

## Verification
The assertions rely on three properties of the inputs. A request is a single-cycle pulse. `dist_rdata` is settled whenever `dist_req` is high. `pend_set` and `pend_clr` stay low while the bench checks the trigger-bounds property. The bench drives each request for exactly one cycle and then leaves an idle cycle before the next one. It holds the pending inputs low during the random phase and touches them only in directed steps that do not overlap any trigger write. It computes the distributor read data as a fixed function of `dist_addr`, so that value is stable inside the cycle.

// File: rtl/intc_sysreg_pkg.sv
package intc_sysreg_pkg;

  localparam int VEC_W      = 10;
  localparam int NONE_VEC   = 1023;
  localparam int FLAG_BIT   = 16;
  localparam int RELOAD_W   = 24;
  localparam int CTRL_W     = 3;

  localparam logic [11:0] OFF_LINES  = 12'h004;
  localparam logic [11:0] OFF_TCTRL  = 12'h010;
  localparam logic [11:0] OFF_TRLD   = 12'h014;
  localparam logic [11:0] OFF_STATE  = 12'hD04;
  localparam logic [11:0] OFF_TRIG   = 12'hF00;
  localparam logic [11:0] DIST_LO    = 12'h100;
  localparam logic [11:0] DIST_HI    = 12'hCFF;
  localparam logic [11:0] ID_BASE    = 12'hFE0;

  typedef enum logic [2:0] {
    RK_NONE, RK_LINES, RK_TCTRL, RK_TRLD, RK_STATE, RK_TRIG, RK_DIST, RK_ID
  } reg_kind_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd1:    return 8'hB0;
      3'd2:    return 8'h1B;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hE0;
      3'd6:    return 8'h05;
      3'd7:    return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] lines_word(input int n_irq);
    return 32'(n_irq / 32 - 1);
  endfunction

  function automatic logic [31:0] state_word(input logic [VEC_W-1:0] vec,
                                             input logic any_ext);
    logic [31:0] w;
    w = '0;
    if (vec != VEC_W'(NONE_VEC)) w[12 +: VEC_W] = vec;
    w[22] = any_ext;
    return w;
  endfunction

endpackage

// File: rtl/intc_sysreg_decode.sv
module intc_sysreg_decode
  import intc_sysreg_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        wr,
  input  logic        word,
  output reg_kind_e   kind,
  output logic        illegal
);
  always_comb begin
    kind    = RK_NONE;
    illegal = 1'b0;
    if (addr >= ID_BASE) begin
      kind    = RK_ID;
      illegal = wr;
    end else if (!word || addr[1:0] != 2'b00) begin
      illegal = 1'b1;
    end else if (addr >= DIST_LO && addr <= DIST_HI) begin
      kind = RK_DIST;
    end else begin
      case (addr)
        OFF_LINES: kind = RK_LINES;
        OFF_TCTRL: kind = RK_TCTRL;
        OFF_TRLD:  kind = RK_TRLD;
        OFF_STATE: kind = RK_STATE;
        OFF_TRIG:  begin kind = RK_TRIG; illegal = !wr; end
        default:   illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/intc_tick_regs.sv
module intc_tick_regs
  import intc_sysreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_ctrl,
  input  logic                wr_ctrl,
  input  logic                wr_reload,
  input  logic [31:0]         wdata,
  input  logic                flag_pulse,
  output logic [CTRL_W-1:0]   ctrl_bits,
  output logic [RELOAD_W-1:0] reload_val,
  output logic [31:0]         ctrl_word
);
  logic count_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_bits  <= '0;
      reload_val <= '0;
      count_flag <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_bits  <= wdata[CTRL_W-1:0];
      if (wr_reload) reload_val <= wdata[RELOAD_W-1:0];
      if (flag_pulse)   count_flag <= 1'b1;
      else if (rd_ctrl) count_flag <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_W-1:0] = ctrl_bits;
    ctrl_word[FLAG_BIT]   = count_flag;
  end

  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pulse |=> count_flag);
  a_r8_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !flag_pulse) |=> !count_flag);
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic               trig_wr,
  input  logic [8:0]         trig_num,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic               any_ext
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               trig_hit;
  logic [NUM_IRQ-1:0] pend_d;

  assign trig_hit = trig_wr && (int'(trig_num) < NUM_IRQ);

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (set_i[i] || (trig_hit && trig_num == 9'(i))) pend_d[i] = 1'b1;
      else if (clr_i[i])                               pend_d[i] = 1'b0;
      else                                             pend_d[i] = pend_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  generate
    if (NUM_IRQ > 32) begin : g_ext
      assign any_ext = |pend_q[NUM_IRQ-1:32];
    end else begin : g_noext
      assign any_ext = 1'b0;
    end
  endgenerate

  logic             hit_q;
  logic [IDX_W-1:0] num_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      num_q <= '0;
    end else begin
      hit_q <= trig_hit;
      num_q <= trig_num[IDX_W-1:0];
    end
  end

  a_r12_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> pend_q[num_q]);
  a_r12_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !trig_hit && set_i == '0 && clr_i == '0) |=> $stable(pend_q));
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/intc_sysreg_front.sv
module intc_sysreg_front
  import intc_sysreg_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic [11:0]         bus_addr,
  input  logic                bus_word,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_ready,
  output logic                bus_err,
  output logic                dist_req,
  output logic                dist_wr,
  output logic [11:0]         dist_addr,
  output logic [31:0]         dist_wdata,
  input  logic [31:0]         dist_rdata,
  input  logic [9:0]          hp_vec,
  input  logic                tick_flag_pulse,
  output logic [2:0]          tick_ctrl_o,
  output logic [23:0]         tick_reload_o,
  input  logic [NUM_IRQ-1:0]  pend_set,
  input  logic [NUM_IRQ-1:0]  pend_clr,
  output logic [NUM_IRQ-1:0]  pend_o,
  output logic                ctl_enable_o,
  output logic                cpu_if_enable_o
);
  reg_kind_e   kind;
  logic        illegal;
  logic        acc_ok, acc_rd, acc_wr;
  logic        rd_ctrl, wr_ctrl, wr_reload, trig_wr;
  logic        any_ext;
  logic [31:0] ctrl_word;
  logic [31:0] rd_val;

  intc_sysreg_decode u_decode (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .word    (bus_word),
    .kind    (kind),
    .illegal (illegal)
  );

  assign acc_ok    = bus_req && !illegal;
  assign acc_rd    = acc_ok && !bus_wr;
  assign acc_wr    = acc_ok && bus_wr;
  assign rd_ctrl   = acc_rd && kind == RK_TCTRL;
  assign wr_ctrl   = acc_wr && kind == RK_TCTRL;
  assign wr_reload = acc_wr && kind == RK_TRLD;
  assign trig_wr   = acc_wr && kind == RK_TRIG;

  assign dist_req   = acc_ok && kind == RK_DIST;
  assign dist_wr    = bus_wr;
  assign dist_addr  = bus_addr;
  assign dist_wdata = bus_wdata;

  intc_tick_regs u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ctrl    (rd_ctrl),
    .wr_ctrl    (wr_ctrl),
    .wr_reload  (wr_reload),
    .wdata      (bus_wdata),
    .flag_pulse (tick_flag_pulse),
    .ctrl_bits  (tick_ctrl_o),
    .reload_val (tick_reload_o),
    .ctrl_word  (ctrl_word)
  );

  intc_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (pend_set),
    .clr_i    (pend_clr),
    .trig_wr  (trig_wr),
    .trig_num (bus_wdata[8:0]),
    .pend_q   (pend_o),
    .any_ext  (any_ext)
  );

  always_comb begin
    case (kind)
      RK_ID:    rd_val = (bus_addr[1:0] != 2'b00) ? 32'h0
                         : {24'h0, id_byte(bus_addr[4:2])};
      RK_LINES: rd_val = lines_word(NUM_IRQ);
      RK_TCTRL: rd_val = ctrl_word;
      RK_TRLD:  rd_val = {8'h0, tick_reload_o};
      RK_STATE: rd_val = state_word(hp_vec, any_ext);
      RK_DIST:  rd_val = dist_rdata;
      default:  rd_val = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready       <= 1'b0;
      bus_err         <= 1'b0;
      bus_rdata       <= '0;
      ctl_enable_o    <= 1'b1;
      cpu_if_enable_o <= 1'b1;
    end else begin
      bus_ready <= bus_req;
      bus_err   <= bus_req && illegal;
      bus_rdata <= acc_rd ? rd_val : 32'h0;
    end
  end

  a_r2_ready_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  a_r2_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ready && bus_rdata == 32'h0));
  a_r3_dist_only_word: assert property (@(posedge clk) disable iff (!rst_n)
    dist_req |-> (bus_req && bus_word && bus_addr >= DIST_LO && bus_addr <= DIST_HI));
  a_r5_unaligned_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_addr >= ID_BASE && bus_addr[1:0] != 2'b00)
      |=> (bus_rdata == 32'h0 && !bus_err));
endmodule

// File: tb/intc_sysreg_front_tb_top.sv
`timescale 1ns/1ps
module intc_sysreg_front_tb_top;
  localparam int NIRQ = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_req = 1'b0, bus_wr = 1'b0, bus_word = 1'b1;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_ready, bus_err;
  logic             dist_req, dist_wr;
  logic [11:0]      dist_addr;
  logic [31:0]      dist_wdata, dist_rdata;
  logic [9:0]       hp_vec = 10'd1023;
  logic             tick_flag_pulse = 1'b0;
  logic [2:0]       tick_ctrl_o;
  logic [23:0]      tick_reload_o;
  logic [NIRQ-1:0]  pend_set = '0, pend_clr = '0, pend_o;
  logic             ctl_enable_o, cpu_if_enable_o;

  always #10 clk = ~clk;

  function automatic logic [31:0] dist_fn(input logic [11:0] a);
    return 32'h5D00_0000 ^ {a, 8'h00, a[7:0], 4'h3};
  endfunction
  assign dist_rdata = dist_fn(dist_addr);

  intc_sysreg_front #(.NUM_IRQ(NIRQ)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0]       m_ctrl = '0;
  logic             m_flag = 1'b0;
  logic [23:0]      m_rld = '0;
  logic [NIRQ-1:0]  m_pend = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ident(input int k);
    logic [7:0] t [8] = '{8'h00, 8'hB0, 8'h1B, 8'h00, 8'h0D, 8'hE0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic predict(input bit wr, input logic [11:0] a, input bit word,
                         input logic [31:0] wd, input bit pulse,
                         output bit e_err, output logic [31:0] e_rd,
                         output bit e_dist);
    int off = int'(a);
    e_err = 0; e_rd = 0; e_dist = 0;
    if (off >= 4064) begin
      if (wr) e_err = 1;
      else if (off % 4 == 0) e_rd = {24'h0, ident((off - 4064) / 4)};
    end else if (!word || off % 4 != 0) e_err = 1;
    else if (off >= 256 && off < 3328) begin
      e_dist = 1;
      if (!wr) e_rd = dist_fn(a);
    end else if (off == 4) begin
      if (!wr) e_rd = NIRQ / 32 - 1;
    end else if (off == 16) begin
      if (wr) m_ctrl = wd[2:0];
      else begin e_rd = {15'h0, m_flag, 13'h0, m_ctrl}; m_flag = 0; end
    end else if (off == 20) begin
      if (wr) m_rld = wd[23:0]; else e_rd = {8'h0, m_rld};
    end else if (off == 3332) begin
      if (!wr) begin
        if (hp_vec != 10'd1023) e_rd[21:12] = hp_vec;
        e_rd[22] = |m_pend[NIRQ-1:32];
      end
    end else if (off == 3840) begin
      if (!wr) e_err = 1;
      else if (int'(wd[8:0]) < NIRQ) m_pend[wd[8:0]] = 1'b1;
    end else e_err = 1;
    if (pulse) m_flag = 1;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input bit word,
                        input logic [31:0] wd, input bit pulse, input string req);
    bit e_err, e_dist;
    logic [31:0] e_rd;
    @(negedge clk);
    predict(wr, a, word, wd, pulse, e_err, e_rd, e_dist);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_word = word; bus_wdata = wd;
    tick_flag_pulse = pulse;
    #1;
    check(dist_req == e_dist && (!e_dist || (dist_addr == a && dist_wr == wr
          && dist_wdata == wd)), {req, " R3 dist"}, 64'(dist_req), 64'(e_dist));
    @(negedge clk);
    check(bus_ready === 1'b1, {req, " R2 ready"}, 64'(bus_ready), 64'd1);
    check(bus_err === e_err, {req, " R6 err"}, 64'(bus_err), 64'(e_err));
    check(bus_rdata === e_rd, {req, " rdata"}, 64'(bus_rdata), 64'(e_rd));
    check(pend_o === m_pend, {req, " R12 pend"}, 64'(pend_o), 64'(m_pend));
    check(tick_ctrl_o === m_ctrl && tick_reload_o === m_rld, {req, " R10 tick outs"},
          {29'h0, tick_ctrl_o, 8'h0, tick_reload_o}, {29'h0, m_ctrl, 8'h0, m_rld});
    bus_req = 0; tick_flag_pulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(bus_ready === 0 && bus_err === 0 && bus_rdata === 0, "R1 bus idle",
          64'(bus_rdata), 64'd0);
    check(tick_ctrl_o === 0 && tick_reload_o === 0 && pend_o === 0, "R1 zero regs",
          64'(pend_o), 64'd0);
    check(ctl_enable_o === 1 && cpu_if_enable_o === 1, "R1 enables",
          64'({ctl_enable_o, cpu_if_enable_o}), 64'd3);
    access(0, 12'h010, 1, 0, 0, "R1 ctrl read");
    // R7 line count, R14 ignored writes
    access(0, 12'h004, 1, 0, 0, "R7 lines");
    access(1, 12'h004, 1, 32'hFFFF_FFFF, 0, "R14 write lines");
    access(1, 12'hD04, 1, 32'hFFFF_FFFF, 0, "R14 write state");
    access(0, 12'h004, 1, 0, 0, "R14 lines after write");
    // R4 / R5 identification
    for (int k = 0; k < 8; k++) access(0, 12'(4064 + 4 * k), k[0], 0, 0, "R4 id");
    access(0, 12'hFE5, 0, 0, 0, "R5 unaligned id byte");
    access(0, 12'hFFF, 1, 0, 0, "R5 unaligned id word");
    // R6 illegal forms
    access(1, 12'hFE0, 1, 32'h1, 0, "R6 id write");
    access(1, 12'h010, 0, 32'h7, 0, "R6 byte ctrl write");
    access(1, 12'h012, 1, 32'h7, 0, "R6 unaligned ctrl");
    access(0, 12'hF00, 1, 0, 0, "R6 trig read");
    access(0, 12'h020, 1, 0, 0, "R6 undecoded");
    access(0, 12'h100, 0, 0, 0, "R6 byte dist");
    // R8 / R9 count flag
    access(1, 12'h010, 1, 32'h0001_0005, 0, "R8 ctrl write");
    @(negedge clk); tick_flag_pulse = 1; m_flag = 1;
    @(negedge clk); tick_flag_pulse = 0;
    access(0, 12'h010, 1, 0, 0, "R9 flag set read");
    access(0, 12'h010, 1, 0, 0, "R8 flag cleared");
    access(0, 12'h010, 1, 0, 1, "R9 pulse with read");
    access(0, 12'h010, 1, 0, 0, "R9 pulse won");
    // R10 reload
    access(1, 12'h014, 1, 32'hABCD_EF12, 0, "R10 reload write");
    access(0, 12'h014, 1, 0, 0, "R10 reload read");
    // R12 trigger bounds, R11 state
    access(1, 12'hF00, 1, 32'h0000_003F, 0, "R12 trig 63");
    access(1, 12'hF00, 1, 32'h0000_0040, 0, "R12 trig 64 ignored");
    access(1, 12'hF00, 1, 32'hFFFF_FE05, 0, "R12 trig upper bits");
    hp_vec = 10'd77;
    access(0, 12'hD04, 1, 0, 0, "R11 state vec");
    hp_vec = 10'd1023;
    access(0, 12'hD04, 1, 0, 0, "R11 state none");
    // R13 set/clear
    @(negedge clk); pend_clr[63] = 1; pend_clr[5] = 1; pend_set[5] = 1;
    @(negedge clk); pend_clr = '0; pend_set = '0; m_pend[63] = 0;
    check(pend_o === m_pend, "R13 set wins/clear", 64'(pend_o), 64'(m_pend));
    access(0, 12'hD04, 1, 0, 0, "R11 no external");
    @(negedge clk); pend_set[40] = 1;
    @(negedge clk); pend_set = '0; m_pend[40] = 1;
    check(pend_o === m_pend, "R13 set", 64'(pend_o), 64'(m_pend));
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int sel = $urandom_range(0, 8);
      case (sel)
        0: a = 12'h004;
        1: a = 12'h010;
        2: a = 12'h014;
        3: a = 12'hD04;
        4: a = 12'hF00;
        5: a = 12'(12'h100 + $urandom_range(0, 3071));
        6: a = 12'(12'hFE0 + $urandom_range(0, 31));
        default: a = 12'($urandom);
      endcase
      hp_vec = ($urandom_range(0, 3) == 0) ? 10'd1023 : 10'($urandom);
      if (n % 97 == 96) begin
        @(negedge clk); pend_clr = '1;
        @(negedge clk); pend_clr = '0; m_pend = '0;
      end
      access($urandom_range(0, 1), a, $urandom_range(0, 5) != 0,
             (sel == 4) ? 32'($urandom_range(0, 127)) : $urandom,
             $urandom_range(0, 9) == 0, "rand R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule